// File: doc/BRIEF.md
# Overwriting Message Ring Buffer

This block is a first-in first-out store for received bus messages. Each entry carries a 16-bit identifier, an 8-bit length and eight payload bytes. A producer may push one message in any cycle, and a consumer pops messages in the order they arrived. The current fill level is always visible on an output.

The buffer never refuses a push. When it is already full, the newest message replaces the oldest one, the fill level stays at the depth, and a one-cycle flag marks the loss. A pop from an empty buffer still answers: it returns a message whose fields are all zero, so a reader never sees stale contents.

Pop results are registered and appear one cycle after the request, together with a valid strobe. A synchronous clear input empties the buffer. The depth is a parameter from 1 to 255, with 50 as the default.

Top module: `msg_ring`

## Requirements
- R1: A push with no pop while not full stores the message and raises `fill_count` by one on the next cycle. Messages leave in the order they entered.
- R2: A pop while not empty asserts `pop_valid` on the next cycle. In that cycle `pop_id`, `pop_len` and `pop_data` hold the oldest entry, and `fill_count` drops by one. With no request, `pop_valid` is low.
- R3: A push with no pop while `fill_count` equals DEPTH discards the oldest entry and keeps the new one. `fill_count` stays at DEPTH, and `overwrite` is high for exactly the next cycle.
- R4: A pop while empty (and no push) gives `pop_valid` high on the next cycle with identifier, length and all data bytes zero. `fill_count` stays at zero.
- R5: A push and a pop in the same cycle, with the buffer neither empty nor full, leave `fill_count` unchanged. The pop returns the entry that was oldest before the push.
- R6: A push and a pop in the same cycle while full return the oldest entry and store the new one. `fill_count` stays at DEPTH and `overwrite` stays low.
- R7: A push and a pop in the same cycle while empty return an all-zero message, store the pushed one, and make `fill_count` one.
- R8: `clr` high empties the buffer and takes priority over a push or pop in the same cycle. On the next cycle `fill_count` is zero and `pop_valid` and `overwrite` are low. A following pop returns an all-zero message.
- R9: While `rst` is high, and on the cycle after it, `fill_count` is zero and `pop_valid` and `overwrite` are low.
- R10: The read and write positions wrap correctly for a DEPTH that is not a power of two. FIFO order is kept across several wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of positions and fill level |
| push_en | input | 1 | Store the message presented this cycle |
| push_id | input | 16 | Identifier of the pushed message |
| push_len | input | 8 | Length field of the pushed message |
| push_data | input | 64 | Payload, byte 0 in bits 7:0 |
| pop_en | input | 1 | Pop request |
| pop_valid | output | 1 | Pop result valid, one cycle after the request |
| pop_id | output | 16 | Identifier of the popped message |
| pop_len | output | 8 | Length field of the popped message |
| pop_data | output | 64 | Payload of the popped message, byte 0 in bits 7:0 |
| fill_count | output | $clog2(DEPTH+1) | Entries currently held |
| overwrite | output | 1 | One-cycle flag: a push replaced the oldest entry |

## Verification
The bench builds the block with DEPTH set to 3. This depth is not a power of two, so a wrong wrap compare shows up as reordered or lost messages within a few pushes. It also lets nine pushes wrap the write position three times. The small depth makes the full state reachable in three cycles, so overwrite, full-state push with pop, and empty-state push with pop all follow one another in a short stimulus table.

// File: rtl/msg_ring_pkg.sv
package msg_ring_pkg;

    localparam int ID_W    = 16;
    localparam int LEN_W   = 8;
    localparam int NBYTES  = 8;
    localparam int DATA_W  = NBYTES * 8;

    typedef struct packed {
        logic [ID_W-1:0]         ident;
        logic [LEN_W-1:0]        len;
        logic [NBYTES-1:0][7:0]  payload;
    } msg_t;

    localparam msg_t MSG_ZERO = '0;

    function automatic msg_t make_msg(input logic [ID_W-1:0] id,
                                      input logic [LEN_W-1:0] ln,
                                      input logic [DATA_W-1:0] d);
        msg_t m;
        m.ident   = id;
        m.len     = ln;
        m.payload = d;
        return m;
    endfunction

endpackage

// File: rtl/ring_index.sv
module ring_index #(
    parameter int DEPTH = 50,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (step)
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/ring_mem.sv
module ring_mem
    import msg_ring_pkg::*;
#(
    parameter int DEPTH = 50,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  msg_t             wdata,
    input  logic [IDX_W-1:0] raddr,
    output msg_t             rdata
);
    msg_t slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            slots[waddr] <= wdata;
    end

    // read returns the contents before any write in the same cycle
    assign rdata = slots[raddr];
endmodule

// File: rtl/msg_ring.sv
module msg_ring
    import msg_ring_pkg::*;
#(
    parameter int DEPTH = 50,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push_en,
    input  logic [ID_W-1:0]   push_id,
    input  logic [LEN_W-1:0]  push_len,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_en,
    output logic              pop_valid,
    output logic [ID_W-1:0]   pop_id,
    output logic [LEN_W-1:0]  pop_len,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fill_count,
    output logic              overwrite
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

    logic             wipe;
    logic             is_full, is_empty;
    logic             do_push, do_pop, do_drop;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    msg_t             head_msg, out_msg;

    assign wipe     = rst | clr;
    assign is_full  = (fill_count == FULL_LVL);
    assign is_empty = (fill_count == '0);
    assign do_push  = push_en & ~clr;
    assign do_pop   = pop_en & ~clr & ~is_empty;
    // full and not popping: the oldest entry is replaced
    assign do_drop  = do_push & is_full & ~do_pop;

    ring_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_wr (
        .clk (clk),
        .rst (wipe),
        .step(do_push),
        .idx (wr_idx)
    );

    // When full the read position equals the write position, so stepping it
    // on a drop lands it on the write position after the push.
    ring_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_rd (
        .clk (clk),
        .rst (wipe),
        .step(do_pop | do_drop),
        .idx (rd_idx)
    );

    ring_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk  (clk),
        .we   (do_push),
        .waddr(wr_idx),
        .wdata(make_msg(push_id, push_len, push_data)),
        .raddr(rd_idx),
        .rdata(head_msg)
    );

    always_ff @(posedge clk) begin
        if (wipe) begin
            fill_count <= '0;
        end else begin
            unique case ({do_push, do_pop})
                2'b10:   if (!is_full) fill_count <= fill_count + 1'b1;
                2'b01:   fill_count <= fill_count - 1'b1;
                default: fill_count <= fill_count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            pop_valid <= 1'b0;
            overwrite <= 1'b0;
            out_msg   <= MSG_ZERO;
        end else begin
            pop_valid <= pop_en;
            overwrite <= do_drop;
            if (pop_en)
                out_msg <= is_empty ? MSG_ZERO : head_msg;
        end
    end

    assign pop_id   = out_msg.ident;
    assign pop_len  = out_msg.len;
    assign pop_data = out_msg.payload;
endmodule

// File: rtl/msg_ring_chk.sv
module msg_ring_chk
    import msg_ring_pkg::*;
#(
    parameter int DEPTH = 50,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              clr,
    input logic              push_en,
    input logic              pop_en,
    input logic              pop_valid,
    input logic [ID_W-1:0]   pop_id,
    input logic [LEN_W-1:0]  pop_len,
    input logic [DATA_W-1:0] pop_data,
    input logic [CNT_W-1:0]  fill_count,
    input logic              overwrite
);
    localparam logic [CNT_W-1:0] LVL = CNT_W'(DEPTH);

    // R1
    push_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && !clr && fill_count < LVL)
        |=> fill_count == $past(fill_count) + 1'b1);

    // R2
    pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && !clr && fill_count != '0)
        |=> (pop_valid && fill_count == $past(fill_count) - 1'b1));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && !clr && fill_count == LVL)
        |=> (overwrite && fill_count == LVL));

    // R3
    ovf_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        overwrite |-> fill_count == LVL);

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && !clr && fill_count == '0)
        |=> (pop_valid && pop_id == '0 && pop_len == '0 && pop_data == '0
             && fill_count == '0));

    // R5
    mid_both_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && !clr && fill_count != '0 && fill_count != LVL)
        |=> fill_count == $past(fill_count));

    // R6
    full_both_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && !clr && fill_count == LVL)
        |=> (fill_count == LVL && !overwrite && pop_valid));

    // R7
    empty_both_chk: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en && !clr && fill_count == '0)
        |=> (fill_count == 1 && pop_valid && pop_id == '0 && pop_data == '0));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fill_count == '0 && !pop_valid && !overwrite));

    // R9
    reset_chk: assert property (@(posedge clk)
        rst |=> (fill_count == '0 && !pop_valid && !overwrite));

    // R1
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= LVL);
endmodule

bind msg_ring msg_ring_chk #(.DEPTH(DEPTH)) u_msg_ring_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .pop_valid (pop_valid),
    .pop_id    (pop_id),
    .pop_len   (pop_len),
    .pop_data  (pop_data),
    .fill_count(fill_count),
    .overwrite (overwrite)
);

// File: tb/test_msg_ring.sv
module test_msg_ring;
    import msg_ring_pkg::*;

    localparam int DEPTH = 3;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              push_en = 1'b0;
    logic [ID_W-1:0]   push_id = '0;
    logic [LEN_W-1:0]  push_len = '0;
    logic [DATA_W-1:0] push_data = '0;
    logic              pop_en = 1'b0;
    logic              pop_valid;
    logic [ID_W-1:0]   pop_id;
    logic [LEN_W-1:0]  pop_len;
    logic [DATA_W-1:0] pop_data;
    logic [CNT_W-1:0]  fill_count;
    logic              overwrite;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    msg_ring #(.DEPTH(DEPTH)) i_msg_ring (
        .clk(clk), .rst(rst), .clr(clr),
        .push_en(push_en), .push_id(push_id), .push_len(push_len),
        .push_data(push_data), .pop_en(pop_en),
        .pop_valid(pop_valid), .pop_id(pop_id), .pop_len(pop_len),
        .pop_data(pop_data), .fill_count(fill_count), .overwrite(overwrite)
    );

    typedef struct packed {
        logic       push;
        logic       pop;
        logic [7:0] tag;
        logic [7:0] cnt;
        logic       vld;
        logic [7:0] etag;
        logic       ovf;
        logic [3:0] req;
    } step_t;

    // push, pop, push tag, count after, valid, popped tag (0 = zero msg), overwrite, requirement
    localparam step_t TBL [17] = '{
        '{1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd0, 1'b0, 4'd4},  // R4 pop on empty
        '{1'b1, 1'b0, 8'd1, 8'd1, 1'b0, 8'd0, 1'b0, 4'd1},  // R1
        '{1'b1, 1'b0, 8'd2, 8'd2, 1'b0, 8'd0, 1'b0, 4'd1},
        '{1'b1, 1'b0, 8'd3, 8'd3, 1'b0, 8'd0, 1'b0, 4'd1},
        '{1'b1, 1'b0, 8'd4, 8'd3, 1'b0, 8'd0, 1'b1, 4'd3},  // R3 drop tag 1
        '{1'b1, 1'b0, 8'd5, 8'd3, 1'b0, 8'd0, 1'b1, 4'd3},  // R3 drop tag 2
        '{1'b0, 1'b1, 8'd0, 8'd2, 1'b1, 8'd3, 1'b0, 4'd2},  // R2
        '{1'b1, 1'b1, 8'd6, 8'd2, 1'b1, 8'd4, 1'b0, 4'd5},  // R5
        '{1'b1, 1'b0, 8'd7, 8'd3, 1'b0, 8'd0, 1'b0, 4'd1},
        '{1'b1, 1'b1, 8'd8, 8'd3, 1'b1, 8'd5, 1'b0, 4'd6},  // R6
        '{1'b0, 1'b1, 8'd0, 8'd2, 1'b1, 8'd6, 1'b0, 4'd10}, // R10 order across wraps
        '{1'b0, 1'b1, 8'd0, 8'd1, 1'b1, 8'd7, 1'b0, 4'd10},
        '{1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd8, 1'b0, 4'd10},
        '{1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd0, 1'b0, 4'd4},
        '{1'b1, 1'b1, 8'd9, 8'd1, 1'b1, 8'd0, 1'b0, 4'd7},  // R7
        '{1'b0, 1'b1, 8'd0, 8'd0, 1'b1, 8'd9, 1'b0, 4'd2},
        '{1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 8'd0, 1'b0, 4'd2}
    };

    function automatic msg_t tag_msg(input logic [7:0] t);
        msg_t m;
        m.ident = {8'hA5, t};
        m.len   = t ^ 8'h3C;
        for (int j = 0; j < NBYTES; j++)
            m.payload[j] = t + 8'(j * 16);
        return m;
    endfunction

    task automatic check(input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic ps, input logic [7:0] t, input logic pp,
                         input logic cl);
        msg_t m;
        m = tag_msg(t);
        push_en   = ps;
        pop_en    = pp;
        clr       = cl;
        push_id   = m.ident;
        push_len  = m.len;
        push_data = m.payload;
        @(negedge clk);
        push_en = 1'b0;
        pop_en  = 1'b0;
        clr     = 1'b0;
    endtask

    task automatic check_msg(input int req, input logic [7:0] etag);
        msg_t e;
        e = (etag == 8'd0) ? MSG_ZERO : tag_msg(etag);
        check(req, "pop_id", 64'(pop_id), 64'(e.ident));
        check(req, "pop_len", 64'(pop_len), 64'(e.len));
        check(req, "pop_data", pop_data, e.payload);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 while reset is held
        check(9, "count in reset", 64'(fill_count), 64'd0);
        check(9, "valid in reset", 64'(pop_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(9, "overwrite after reset", 64'(overwrite), 64'd0);

        foreach (TBL[i]) begin
            drive(TBL[i].push, TBL[i].tag, TBL[i].pop, 1'b0);
            check(int'(TBL[i].req), $sformatf("step %0d count", i),
                  64'(fill_count), 64'(TBL[i].cnt));
            check(int'(TBL[i].req), $sformatf("step %0d valid", i),
                  64'(pop_valid), 64'(TBL[i].vld));
            check(int'(TBL[i].req), $sformatf("step %0d overwrite", i),
                  64'(overwrite), 64'(TBL[i].ovf));
            if (TBL[i].vld)
                check_msg(int'(TBL[i].req), TBL[i].etag);
        end

        // R8: clear beats a simultaneous push and pop
        drive(1'b1, 8'd20, 1'b0, 1'b0);
        drive(1'b1, 8'd21, 1'b0, 1'b0);
        check(8, "count before clear", 64'(fill_count), 64'd2);
        drive(1'b1, 8'd22, 1'b1, 1'b1);
        check(8, "count after clear", 64'(fill_count), 64'd0);
        check(8, "valid after clear", 64'(pop_valid), 64'd0);
        drive(1'b0, 8'd0, 1'b1, 1'b0);
        check(8, "pop after clear valid", 64'(pop_valid), 64'd1);
        check_msg(8, 8'd0);
        // R8: positions restart cleanly after clear
        drive(1'b1, 8'd23, 1'b0, 1'b0);
        drive(1'b0, 8'd0, 1'b1, 1'b0);
        check_msg(8, 8'd23);

        // R3: overwrite flag lasts one cycle only
        for (int k = 0; k < DEPTH + 1; k++)
            drive(1'b1, 8'(30 + k), 1'b0, 1'b0);
        check(3, "overwrite raised", 64'(overwrite), 64'd1);
        drive(1'b0, 8'd0, 1'b0, 1'b0);
        check(3, "overwrite dropped", 64'(overwrite), 64'd0);
        drive(1'b0, 8'd0, 1'b1, 1'b0);
        check_msg(3, 8'd31);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule